// File: doc/BRIEF.md
# Bus-Attached Asynchronous Serial Port

This block is a byte-wide serial port that a small processor drives through four registers selected by two address bits. Software writes a byte to the data register. The transmitter frames the byte as one start bit, eight data bits sent least significant bit first, and one stop bit. The receiver rebuilds incoming frames into a holding register that software reads from the same address. A status register reports when transmit space is free and when a received byte is waiting. It also reports errors and the interrupt state. A command register enables the port and selects interrupt sources. A control register selects the bit rate from a clock-derived generator.

The whole block runs on one clock, `clk`, which doubles as the rate reference (nominally 1.8432 MHz). A 16x sample tick is produced by dividing `clk` by `DIV_SLOW >> k`, where k comes from the control rate code. With the default `DIV_SLOW = 48` this gives 2400, 4800, 9600 and 19200 baud. `DIV_SLOW` must be a multiple of 8. Bus strobes are synchronous: each access holds `cs` with `rd` or `wr` high for exactly one `clk` cycle. `rdata` is combinational from `addr`, so read data is valid during the strobe cycle.

The transmitter is a state machine with states TX_IDLE, TX_START, TX_DATA and TX_STOP. Its transitions are:
- **load**: TX_IDLE to TX_START when a byte is held and the port runs.
- **start-done**: TX_START to TX_DATA after 16 ticks.
- **last-bit**: TX_DATA to TX_STOP after 8 bits.
- **frame-done**: TX_STOP to TX_IDLE after 16 ticks.
- **abort**: any state to TX_IDLE on soft reset or when the port stops.

The receiver is a state machine with states RX_IDLE, RX_START, RX_DATA and RX_STOP. Its transitions are:
- **edge**: RX_IDLE to RX_START when a tick sees the line low.
- **confirm**: RX_START to RX_DATA when the line is still low 8 ticks later.
- **false-start**: RX_START to RX_IDLE when the line is high at that point.
- **last-bit**: RX_DATA to RX_STOP after 8 samples spaced 16 ticks apart.
- **stop-sampled**: RX_STOP to RX_IDLE at mid stop bit.
- **abort**: any state to RX_IDLE on soft reset, when the port stops, or when carrier is lost.

Top module: `acia_port`

## Requirements
- R1: Registers are selected by `addr`. Offset 0 reads the receive byte and writes the transmit byte. Offset 1 reads status. Offset 2 reads and writes the command byte. Offset 3 reads and writes the control byte. Command and control read back exactly the value last written.
- R2: Any write to offset 1, whatever its data, does a soft reset. Command becomes 0x00. Receive-full, overrun, framing and interrupt clear. Transmit-empty sets. A frame in progress is dropped and `txd_o` returns high. Control keeps its value.
- R3: Status bit 4 is 1 when the transmit holding register is empty. A data write clears it from the next cycle. It sets again when the byte moves into the shift register.
- R4: A transmitted frame is a low start bit, eight data bits with the least significant bit first, and a high stop bit. Each bit lasts 16 ticks. The line idles high.
- R5: Control bit 4 enables the rate generator. When it is 0, no byte starts transmitting. Control bits 3:0 give k: 0xA gives k=0, 0xC gives k=1, 0xE gives k=2, 0xF gives k=3, and any other code gives k=0. One bit lasts 16·(DIV_SLOW>>k) clocks.
- R6: A received byte, assembled least significant bit first, is placed in the receive register and sets status bit 3. A data read at offset 0 clears status bit 3.
- R7: A frame whose stop bit samples low still delivers its byte and sets status bit 1 (framing error).
- R8: A frame that completes while status bit 3 is set is discarded, and status bit 2 (overrun) sets. Reading data clears bits 1, 2 and 3.
- R9: Command bit 0 enables the port. While it is 0, a held transmit byte stays held with `txd_o` high, and received frames are ignored.
- R10: The interrupt flag drives both `irq_o` and status bit 7. It sets when a byte lands in the receive register while command bit 1 is 0. It also sets when a byte moves to the transmit shift register while command bits 3:2 equal 01. A status read clears it.
- R11: Status bit 5 mirrors `dcd_n` and status bit 6 mirrors `dsr_n`. While `dcd_n` is high, the receiver ignores the line.
- R12: After hardware reset, status is 0x10 (with `dcd_n` and `dsr_n` low), command is 0x00, control is 0x00, `txd_o` is 1 and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock and rate reference |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| cs | input | 1 | Chip select for a bus access |
| rd | input | 1 | One-cycle read strobe |
| wr | input | 1 | One-cycle write strobe |
| addr | input | 2 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line |
| dcd_n | input | 1 | Carrier detect, active low |
| dsr_n | input | 1 | Data set ready, active low |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
Some bus-side rules are checked by assertions on every cycle:
- A data write clears transmit-empty.
- A soft reset clears its state one cycle later.
- A data read drops receive-full.
- An overrun leaves the held byte unchanged.
- A status read clears the interrupt.
- Both state machines return to idle once the port stops.

Other behaviour shows only over whole frames, so the bench's scenarios cover it:
- bit timing for every rate code;
- the bit order on the line;
- receiver sampling and false-start rejection;
- framing and overrun outcomes;
- transmit abort by soft reset;
- a loopback of all 256 byte values.

// File: rtl/acia_pkg.sv
package acia_pkg;

    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_e;
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

    localparam logic [1:0] REG_DATA = 2'd0;
    localparam logic [1:0] REG_STAT = 2'd1;
    localparam logic [1:0] REG_CMD  = 2'd2;
    localparam logic [1:0] REG_CTL  = 2'd3;

    // rate code to divisor shift; unlisted codes run at the slowest rate
    function automatic logic [1:0] rate_shift(input logic [3:0] code);
        case (code)
            4'hA:    rate_shift = 2'd0;
            4'hC:    rate_shift = 2'd1;
            4'hE:    rate_shift = 2'd2;
            4'hF:    rate_shift = 2'd3;
            default: rate_shift = 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/acia_baud.sv
module acia_baud #(
    parameter int DIV_SLOW = 48
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] shift,
    output logic       tick
);
    localparam int CW = $clog2(DIV_SLOW + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;

    assign lim  = CW'(DIV_SLOW >> shift);
    assign tick = run && (cnt_q >= lim - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt_q <= '0;
        else if (!run || tick)     cnt_q <= '0;
        else                       cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/acia_tx.sv
module acia_tx
    import acia_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       run,
    input  logic       tick,
    input  logic       wr,
    input  logic [7:0] wdata,
    output logic       txd,
    output logic       empty,
    output logic       moved
);
    tx_state_e  state_q, state_d;
    logic [3:0] tcnt;
    logic [2:0] bitn;
    logic [7:0] shreg, hold;
    logic       hold_full;
    logic       load, bit_end;

    assign load    = (state_q == TX_IDLE) && hold_full && run && !clr;
    assign bit_end = tick && (tcnt == 4'd15);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (clr || !run) begin
            state_d = TX_IDLE;
        end else begin
            unique case (state_q)
                TX_IDLE:  if (load) state_d = TX_START;
                TX_START: if (bit_end) state_d = TX_DATA;
                TX_DATA:  if (bit_end && bitn == 3'd7) state_d = TX_STOP;
                TX_STOP:  if (bit_end) state_d = TX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt      <= '0;
            bitn      <= '0;
            shreg     <= '0;
            hold      <= '0;
            hold_full <= 1'b0;
        end else if (clr) begin
            tcnt      <= '0;
            bitn      <= '0;
            hold_full <= 1'b0;
        end else begin
            if (load) begin
                shreg     <= hold;
                hold_full <= 1'b0;
                tcnt      <= '0;
                bitn      <= '0;
            end else if (state_q != TX_IDLE && tick) begin
                tcnt <= tcnt + 1'b1;
                if (state_q == TX_DATA && tcnt == 4'd15) begin
                    shreg <= shreg >> 1;
                    bitn  <= bitn + 1'b1;
                end
            end
            if (wr) begin
                hold      <= wdata;
                hold_full <= 1'b1;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            TX_START: txd = 1'b0;
            TX_DATA:  txd = shreg[0];
            TX_IDLE,
            TX_STOP:  txd = 1'b1;
        endcase
        empty = !hold_full;
        moved = load;
    end

    // R9: a stopped port leaves the transmitter idle
    assert_tx_idle_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run) |=> (state_q == TX_IDLE));
endmodule

// File: rtl/acia_rx.sv
module acia_rx
    import acia_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       run,
    input  logic       tick,
    input  logic       rxd,
    output logic       done,
    output logic       ferr,
    output logic [7:0] data
);
    rx_state_e  state_q, state_d;
    logic [1:0] sync_q;
    logic       rxd_s;
    logic [3:0] scnt;
    logic [2:0] bitn;
    logic [7:0] shreg;
    logic       go;

    assign rxd_s = sync_q[1];
    assign go    = run && !clr && tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (clr || !run) begin
            state_d = RX_IDLE;
        end else if (tick) begin
            unique case (state_q)
                RX_IDLE:  if (!rxd_s) state_d = RX_START;
                RX_START: if (scnt == 4'd7) state_d = rxd_s ? RX_IDLE : RX_DATA;
                RX_DATA:  if (scnt == 4'd15 && bitn == 3'd7) state_d = RX_STOP;
                RX_STOP:  if (scnt == 4'd15) state_d = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            scnt   <= '0;
            bitn   <= '0;
            shreg  <= '0;
            done   <= 1'b0;
            ferr   <= 1'b0;
            data   <= '0;
        end else begin
            sync_q <= {sync_q[0], rxd};
            done   <= 1'b0;
            if (go) begin
                if (state_q == RX_IDLE || (state_q == RX_START && scnt == 4'd7))
                    scnt <= '0;
                else
                    scnt <= scnt + 1'b1;
                if (state_q == RX_START)
                    bitn <= '0;
                if (state_q == RX_DATA && scnt == 4'd15) begin
                    shreg <= {rxd_s, shreg[7:1]};
                    bitn  <= bitn + 1'b1;
                end
                if (state_q == RX_STOP && scnt == 4'd15) begin
                    done <= 1'b1;
                    ferr <= !rxd_s;
                    data <= shreg;
                end
            end
        end
    end

    // R11: a stopped receiver (disabled or carrier lost) returns to idle
    assert_rx_idle_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!run) |=> (state_q == RX_IDLE));
endmodule

// File: rtl/acia_port.sv
module acia_port
    import acia_pkg::*;
#(
    parameter int DIV_SLOW = 48
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs,
    input  logic       rd,
    input  logic       wr,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       rxd_i,
    output logic       txd_o,
    input  logic       dcd_n,
    input  logic       dsr_n,
    output logic       irq_o
);
    logic [7:0] cmd_q, ctl_q, rx_data;
    logic       rx_full, ovr_q, ferr_q, irq_q;
    logic       sreset, wr_data, rd_data, rd_stat;
    logic       tick, tx_run, rx_run;
    logic       tx_empty, tx_moved;
    logic       rx_done, rx_ferr;
    logic [7:0] rx_byte;
    logic       rx_take, irq_set;
    logic [7:0] status;

    assign sreset  = cs && wr && (addr == REG_STAT);
    assign wr_data = cs && wr && (addr == REG_DATA);
    assign rd_data = cs && rd && (addr == REG_DATA);
    assign rd_stat = cs && rd && (addr == REG_STAT);

    assign tx_run  = cmd_q[0] && ctl_q[4];
    assign rx_run  = tx_run && !dcd_n;
    assign rx_take = rx_done && (!rx_full || rd_data);
    assign irq_set = (rx_take && !cmd_q[1]) || (tx_moved && cmd_q[3:2] == 2'b01);

    acia_baud #(.DIV_SLOW(DIV_SLOW)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(ctl_q[4]),
        .shift(rate_shift(ctl_q[3:0])), .tick(tick));

    acia_tx u_tx (
        .clk(clk), .rst_n(rst_n), .clr(sreset), .run(tx_run), .tick(tick),
        .wr(wr_data), .wdata(wdata), .txd(txd_o), .empty(tx_empty), .moved(tx_moved));

    acia_rx u_rx (
        .clk(clk), .rst_n(rst_n), .clr(sreset), .run(rx_run), .tick(tick),
        .rxd(rxd_i), .done(rx_done), .ferr(rx_ferr), .data(rx_byte));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            ctl_q   <= '0;
            rx_data <= '0;
            rx_full <= 1'b0;
            ovr_q   <= 1'b0;
            ferr_q  <= 1'b0;
            irq_q   <= 1'b0;
        end else if (sreset) begin
            cmd_q   <= '0;
            rx_full <= 1'b0;
            ovr_q   <= 1'b0;
            ferr_q  <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            if (cs && wr && addr == REG_CMD) cmd_q <= wdata;
            if (cs && wr && addr == REG_CTL) ctl_q <= wdata;
            if (rx_take) begin
                rx_data <= rx_byte;
                rx_full <= 1'b1;
                ferr_q  <= rx_ferr;
                ovr_q   <= 1'b0;
            end else if (rx_done) begin
                ovr_q   <= 1'b1;
            end else if (rd_data) begin
                rx_full <= 1'b0;
                ovr_q   <= 1'b0;
                ferr_q  <= 1'b0;
            end
            if (irq_set)      irq_q <= 1'b1;
            else if (rd_stat) irq_q <= 1'b0;
        end
    end

    always_comb begin
        status = {irq_q, dsr_n, dcd_n, tx_empty, rx_full, ovr_q, ferr_q, 1'b0};
        unique case (addr)
            REG_DATA: rdata = rx_data;
            REG_STAT: rdata = status;
            REG_CMD:  rdata = cmd_q;
            REG_CTL:  rdata = ctl_q;
        endcase
        irq_o = irq_q;
    end

    assert_wr_clears_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data |=> !tx_empty);

    assert_soft_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sreset |=> (tx_empty && !rx_full && !irq_q && cmd_q == 8'h00));

    assert_read_clears_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !rx_done && !sreset) |=> !rx_full);

    assert_overrun_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rx_full && !rd_data && !sreset) |=> (ovr_q && $stable(rx_data)));

    assert_stat_read_clears_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !irq_set) |=> !irq_o);
endmodule

// File: tb/sim_acia_port.sv
module sim_acia_port;
    localparam int CLK_NS = 10;
    localparam int DIV    = 16;
    localparam int FBIT   = 16 * (DIV >> 3);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 0, rd = 0, wr = 0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       drv_rxd = 1'b1, loop_en = 1'b0;
    logic       rxd_i, txd_o;
    logic       dcd_n = 1'b0, dsr_n = 1'b0;
    logic       irq_o;

    int checks = 0;
    int errs   = 0;
    bit finished = 0;

    assign rxd_i = loop_en ? txd_o : drv_rxd;

    always #(CLK_NS/2) clk = ~clk;

    acia_port #(.DIV_SLOW(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rxd_i(rxd_i), .txd_o(txd_o),
        .dcd_n(dcd_n), .dsr_n(dsr_n), .irq_o(irq_o));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cs = 1; wr = 1; addr = a; wdata = d;
        @(negedge clk);
        cs = 0; wr = 0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        cs = 1; rd = 1; addr = a;
        #1 v = rdata;
        @(negedge clk);
        cs = 0; rd = 0;
    endtask

    task automatic wait_stat(input logic [7:0] mask, input int limit, output bit ok);
        logic [7:0] v;
        ok = 0;
        for (int i = 0; i < limit && !ok; i++) begin
            bus_rd(2'd1, v);
            if ((v & mask) != 0) ok = 1;
        end
    endtask

    task automatic send_frame(input logic [7:0] b, input logic stop, input int bclk);
        @(negedge clk);
        drv_rxd = 1'b0;
        repeat (bclk) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            drv_rxd = b[i];
            repeat (bclk) @(negedge clk);
        end
        drv_rxd = stop;
        repeat (bclk) @(negedge clk);
        drv_rxd = 1'b1;
        repeat (2 * bclk) @(negedge clk);
    endtask

    task automatic wait_fall();
        while (txd_o) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++; errs++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] got;
        bit ok;
        int n;
        int lows;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state
        bus_rd(2'd1, v); chk("R12 status", v, 8'h10);
        bus_rd(2'd2, v); chk("R12 command", v, 8'h00);
        bus_rd(2'd3, v); chk("R12 control", v, 8'h00);
        chk("R12 txd", txd_o, 1);
        chk("R12 irq", irq_o, 0);

        // R1 register readback
        bus_wr(2'd2, 8'hA6); bus_rd(2'd2, v); chk("R1 command readback", v, 8'hA6);
        bus_wr(2'd3, 8'h3C); bus_rd(2'd3, v); chk("R1 control readback", v, 8'h3C);
        bus_wr(2'd2, 8'h0B);

        // R5 bit period per rate code (second low bit of 0x55)
        for (int c = 0; c < 5; c++) begin
            logic [3:0] code;
            int k;
            code = (c == 0) ? 4'hA : (c == 1) ? 4'hC : (c == 2) ? 4'hE : (c == 3) ? 4'hF : 4'h8;
            k    = (c < 4) ? c : 0;
            bus_wr(2'd3, {4'h1, code});
            bus_wr(2'd0, 8'h55);
            wait_fall();
            while (!txd_o) @(negedge clk);
            while (txd_o) @(negedge clk);
            n = 0;
            while (!txd_o) begin @(negedge clk); n++; end
            chk($sformatf("R5 bit clocks code %0h", code), n, 16 * (DIV >> k));
            repeat (10 * 16 * (DIV >> k)) @(negedge clk);
        end

        // R4 frame shape at the fastest rate
        bus_wr(2'd3, 8'h1F);
        for (int j = 0; j < 4; j++) begin
            logic [7:0] b;
            b = (j == 0) ? 8'hA5 : (j == 1) ? 8'h3C : (j == 2) ? 8'h00 : 8'hFF;
            bus_wr(2'd0, b);
            wait_fall();
            repeat (FBIT / 2) @(negedge clk);
            chk("R4 start bit", txd_o, 0);
            for (int i = 0; i < 8; i++) begin
                repeat (FBIT) @(negedge clk);
                got[i] = txd_o;
            end
            chk("R4 data order", got, b);
            repeat (FBIT) @(negedge clk);
            chk("R4 stop bit", txd_o, 1);
            repeat (2 * FBIT) @(negedge clk);
        end

        // R6 direct receive and clear on read
        send_frame(8'h96, 1'b1, FBIT);
        bus_rd(2'd1, v); chk("R6 status full", v, 8'h18);
        bus_rd(2'd0, v); chk("R6 data", v, 8'h96);
        bus_rd(2'd1, v); chk("R6 status cleared", v, 8'h10);

        // R7 framing error
        send_frame(8'h3C, 1'b0, FBIT);
        bus_rd(2'd1, v); chk("R7 framing status", v, 8'h1A);
        bus_rd(2'd0, v); chk("R7 data kept", v, 8'h3C);
        bus_rd(2'd1, v); chk("R7 cleared", v, 8'h10);

        // R8 overrun
        send_frame(8'h11, 1'b1, FBIT);
        send_frame(8'h22, 1'b1, FBIT);
        bus_rd(2'd1, v); chk("R8 overrun status", v, 8'h1C);
        bus_rd(2'd0, v); chk("R8 first byte kept", v, 8'h11);
        bus_rd(2'd1, v); chk("R8 cleared by data read", v, 8'h10);

        // R9 disabled port
        bus_wr(2'd2, 8'h0A);
        bus_wr(2'd0, 8'h5A);
        lows = 0;
        for (int i = 0; i < 12 * FBIT; i++) begin @(negedge clk); if (!txd_o) lows++; end
        chk("R9 txd held high", lows, 0);
        bus_rd(2'd1, v); chk("R9 byte still held", v & 8'h10, 0);
        send_frame(8'h77, 1'b1, FBIT);
        bus_rd(2'd1, v); chk("R9 receive ignored", v & 8'h08, 0);
        bus_wr(2'd2, 8'h0B);
        wait_stat(8'h10, 20, ok); chk("R9 byte released", ok, 1);
        repeat (12 * FBIT) @(negedge clk);

        // R5 generator off blocks transmit
        bus_wr(2'd3, 8'h0F);
        bus_wr(2'd0, 8'h00);
        lows = 0;
        for (int i = 0; i < 12 * FBIT; i++) begin @(negedge clk); if (!txd_o) lows++; end
        chk("R5 generator off no output", lows, 0);
        bus_wr(2'd3, 8'h1F);
        repeat (12 * FBIT) @(negedge clk);

        // R10 interrupts
        bus_rd(2'd1, v);
        bus_wr(2'd2, 8'h09);
        send_frame(8'h42, 1'b1, FBIT);
        chk("R10 rx irq raised", irq_o, 1);
        bus_rd(2'd1, v); chk("R10 status bit7", v, 8'h98);
        @(negedge clk); chk("R10 irq cleared", irq_o, 0);
        bus_rd(2'd0, v);
        bus_wr(2'd2, 8'h07);
        bus_wr(2'd0, 8'h00);
        repeat (3) @(negedge clk);
        chk("R10 tx irq raised", irq_o, 1);
        bus_rd(2'd1, v); chk("R10 tx irq status", v, 8'h90);
        @(negedge clk); chk("R10 tx irq cleared", irq_o, 0);
        repeat (12 * FBIT) @(negedge clk);
        bus_wr(2'd2, 8'h0B);
        send_frame(8'h24, 1'b1, FBIT);
        chk("R10 no irq when disabled", irq_o, 0);
        bus_rd(2'd0, v);

        // R11 modem inputs
        dcd_n = 1'b1;
        send_frame(8'h81, 1'b1, FBIT);
        bus_rd(2'd1, v); chk("R11 carrier lost ignores line", v, 8'h30);
        dcd_n = 1'b0; dsr_n = 1'b1;
        bus_rd(2'd1, v); chk("R11 dsr mirrored", v, 8'h50);
        dsr_n = 1'b0;

        // R4/R6 loopback over every byte value
        loop_en = 1'b1;
        for (int b = 0; b < 256; b++) begin
            wait_stat(8'h10, 400, ok);
            bus_wr(2'd0, 8'(b));
            wait_stat(8'h08, 600, ok);
            bus_rd(2'd0, v);
            chk("R6 loopback byte", v, b);
        end
        repeat (4 * FBIT) @(negedge clk);
        loop_en = 1'b0;

        // R2 soft reset
        send_frame(8'h5E, 1'b1, FBIT);
        bus_wr(2'd0, 8'h00);
        repeat (FBIT * 2) @(negedge clk);
        chk("R2 mid-frame line low", txd_o, 0);
        bus_wr(2'd1, 8'hC3);
        chk("R2 txd released", txd_o, 1);
        bus_rd(2'd1, v); chk("R2 status", v, 8'h10);
        bus_rd(2'd2, v); chk("R2 command cleared", v, 8'h00);
        bus_rd(2'd3, v); chk("R2 control kept", v, 8'h1F);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule